// File: doc/BRIEF.md
# Double-Buffered USB OUT Receive Store

This block holds received OUT packets for one endpoint in two equal halves, each large enough for one maximum-size packet. The USB side streams the bytes of a packet into whichever half is next in turn and free. The packet is kept only if it closes with a good end-of-packet strobe and fits the half. A bad packet, or one that is too long, leaves the half free. When the next half in turn is still occupied, the block asks the USB side to answer the host with NAK, and the bytes of that packet are dropped.

The CPU always sees one half at a time. A size output reports the committed byte count of that half. A level request tells the CPU that the half holds a committed packet. The CPU reads bytes one at a time. When it has finished, it pulses a done strobe: the half is freed, the other half becomes visible and the size output is refreshed. Reading past the reported size, or reading while no packet is present, returns a filler byte and sets a sticky error flag. A clear command, used after a bus reset or a cable attach, drops every committed packet and resets the error flags. It never touches a half that is being filled, so a packet in flight still completes.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset both halves are empty, so `cpu_size` is 0 and `rx_ready`, `usb_nak`, `err_over` and `err_empty` are all 0.
- R2: A packet of 0 to MAX_PKT bytes that ends with `usb_eop_good` is committed. When it is the half the CPU sees, `rx_ready` is 1, `cpu_size` equals its byte count, and successive reads return its bytes in arrival order.
- R3: A packet that ends with `usb_eop_bad`, or that carries more than MAX_PKT bytes, is discarded. Its half stays free, and a packet of exactly MAX_PKT bytes is still accepted.
- R4: Two committed packets can be held at once, and the CPU receives them in arrival order. While both halves hold committed packets `usb_nak` is 1, and a packet that arrives then is dropped.
- R5: A `cpu_done` pulse while the visible half is committed frees it and switches to the other half. `cpu_size` and `rx_ready` then reflect the other half, which means 0 if it holds no committed packet.
- R6: A read at or beyond `cpu_size` returns FILL_VAL (default 0xFF), sets `err_over` and does not advance the read position.
- R7: A read while the visible half holds no committed packet returns FILL_VAL and sets `err_empty`.
- R8: `cpu_clear` frees every committed half and clears both error flags. A half that is being filled is left alone, and its packet completes and becomes the visible one.
- R9: A `cpu_done` pulse while the visible half holds no committed packet has no effect on the store.
- R10: `cpu_rdata` and `cpu_rvalid` are valid after the rising edge that samples `cpu_rd`. `cpu_size`, `rx_ready` and `usb_nak` change at the second rising edge after the stimulus that caused the change.
- R11: A zero-length good packet is committed, giving `rx_ready` = 1 with `cpu_size` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_wr | input | 1 | Received byte strobe |
| usb_data | input | DW | Received byte |
| usb_eop_good | input | 1 | End of packet, packet good |
| usb_eop_bad | input | 1 | End of packet, packet bad |
| usb_nak | output | 1 | Next packet would be refused; answer NAK |
| cpu_rd | input | 1 | Read one byte of the visible half |
| cpu_done | input | 1 | Read-finish trigger: free visible half and switch |
| cpu_clear | input | 1 | Drop committed packets and clear error flags |
| cpu_rdata | output | DW | Byte read, or FILL_VAL on an error read |
| cpu_rvalid | output | 1 | `cpu_rdata` updated by the last read |
| cpu_size | output | $clog2(MAX_PKT+1) | Byte count of the visible half |
| rx_ready | output | 1 | Visible half holds a committed packet (interrupt request) |
| err_over | output | 1 | Sticky: read beyond the reported size |
| err_empty | output | 1 | Sticky: read with no committed packet |

## Verification
Read data and the two error flags are due one edge after `cpu_rd`. The bench therefore pulses the read across one rising edge and samples at the following falling edge. The size, ready and NAK outputs are one register stage behind the half state, so they are due two edges after the stimulus. Every packet, done or clear operation waits one extra falling edge before these outputs are compared. One directed case confirms that `rx_ready` is still low at the first falling edge after a good end-of-packet and high at the second.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  typedef enum logic [1:0] {
    HS_FREE = 2'd0,
    HS_FILL = 2'd1,
    HS_FULL = 2'd2
  } half_st_t;
endpackage

// File: rtl/rxpp_ram.sv
module rxpp_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/rxpp_fill.sv
module rxpp_fill #(
  parameter int DW      = 8,
  parameter int MAX_PKT = 64,
  parameter int AW      = $clog2(MAX_PKT),
  parameter int CW      = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          usb_wr,
  input  logic [DW-1:0] usb_data,
  input  logic          eop_good,
  input  logic          eop_bad,
  input  logic          wsel_free,
  output logic          wr_sel,
  output logic          filling,
  output logic          claim,
  output logic          commit,
  output logic          discard,
  output logic [CW-1:0] commit_cnt,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata
);
  localparam logic [CW-1:0] CAP = CW'(MAX_PKT);

  logic          active_q, drop_q, over_q, sel_q;
  logic [CW-1:0] wptr_q;
  logic          eop;

  assign eop        = eop_good || eop_bad;
  assign wr_sel     = sel_q;
  assign filling    = active_q;
  assign commit_cnt = wptr_q;
  assign ram_wdata  = usb_data;

  always_comb begin
    claim     = 1'b0;
    commit    = 1'b0;
    discard   = 1'b0;
    ram_we    = 1'b0;
    ram_waddr = active_q ? wptr_q[AW-1:0] : '0;
    if (eop) begin
      if (active_q) begin
        if (eop_good && !over_q) commit  = 1'b1;
        else                     discard = 1'b1;
      end else if (!drop_q && eop_good && wsel_free) begin
        commit = 1'b1;
      end
    end else if (usb_wr) begin
      if (active_q) begin
        ram_we = (wptr_q < CAP);
      end else if (!drop_q && wsel_free) begin
        claim  = 1'b1;
        ram_we = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      drop_q   <= 1'b0;
      over_q   <= 1'b0;
      sel_q    <= 1'b0;
      wptr_q   <= '0;
    end else begin
      if (commit || discard) begin
        active_q <= 1'b0;
        over_q   <= 1'b0;
        wptr_q   <= '0;
        if (commit) sel_q <= ~sel_q;
      end else if (eop) begin
        drop_q <= 1'b0;
      end else if (claim) begin
        active_q <= 1'b1;
        wptr_q   <= CW'(1);
      end else if (usb_wr && active_q) begin
        if (ram_we) wptr_q <= wptr_q + CW'(1);
        else        over_q <= 1'b1;
      end else if (usb_wr && !active_q) begin
        drop_q <= 1'b1;
      end
    end
  end

  p_wptr_cap_r3: assert property (@(posedge clk) disable iff (rst)
    wptr_q <= CAP);
  p_drop_silent_r4: assert property (@(posedge clk) disable iff (rst)
    drop_q |-> !ram_we);
  p_over_discards_r3: assert property (@(posedge clk) disable iff (rst)
    (over_q && active_q && eop) |-> !commit);
endmodule

// File: rtl/rxpp_reader.sv
module rxpp_reader #(
  parameter int            DW       = 8,
  parameter int            MAX_PKT  = 64,
  parameter logic [DW-1:0] FILL_VAL = '1,
  parameter int            AW       = $clog2(MAX_PKT),
  parameter int            CW       = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_rd,
  input  logic          cpu_done,
  input  logic          cpu_clear,
  input  logic          wr_sel,
  input  logic          sel_full,
  input  logic [CW-1:0] sel_cnt,
  input  logic [DW-1:0] ram_q0,
  input  logic [DW-1:0] ram_q1,
  output logic          rd_sel,
  output logic          release_half,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          err_over,
  output logic          err_empty
);
  logic          sel_q, rvalid_q, fill_q, bsel_q, over_q, empty_q;
  logic [CW-1:0] rptr_q;
  logic          hit;

  assign hit          = cpu_rd && sel_full && (rptr_q < sel_cnt);
  assign ram_re       = hit;
  assign ram_raddr    = rptr_q[AW-1:0];
  assign release_half = cpu_done && sel_full;
  assign rd_sel       = sel_q;
  assign rvalid       = rvalid_q;
  assign err_over     = over_q;
  assign err_empty    = empty_q;
  assign rdata        = fill_q ? FILL_VAL : (bsel_q ? ram_q1 : ram_q0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 1'b0;
      rptr_q   <= '0;
      rvalid_q <= 1'b0;
      fill_q   <= 1'b1;
      bsel_q   <= 1'b0;
      over_q   <= 1'b0;
      empty_q  <= 1'b0;
    end else begin
      rvalid_q <= cpu_rd;
      if (cpu_rd) begin
        fill_q <= !hit;
        bsel_q <= sel_q;
      end
      if (hit) rptr_q <= rptr_q + CW'(1);
      if (cpu_clear) begin
        over_q  <= 1'b0;
        empty_q <= 1'b0;
      end else if (cpu_rd && !hit) begin
        if (sel_full) over_q  <= 1'b1;
        else          empty_q <= 1'b1;
      end
      if (cpu_clear) begin
        sel_q  <= wr_sel;
        rptr_q <= '0;
      end else if (release_half) begin
        sel_q  <= ~sel_q;
        rptr_q <= '0;
      end
    end
  end

  p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_rd |=> rvalid_q);
  p_over_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && sel_full && (rptr_q >= sel_cnt) && !cpu_clear) |=> over_q);
  p_empty_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !sel_full && !cpu_clear) |=> empty_q);
  p_rptr_bound_r6: assert property (@(posedge clk) disable iff (rst)
    sel_full |-> (rptr_q <= sel_cnt));
  p_idle_done_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_done && !sel_full && !cpu_clear) |=> $stable(sel_q));
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf #(
  parameter int            DW       = 8,
  parameter int            MAX_PKT  = 64,
  parameter logic [DW-1:0] FILL_VAL = '1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         usb_wr,
  input  logic [DW-1:0]                usb_data,
  input  logic                         usb_eop_good,
  input  logic                         usb_eop_bad,
  output logic                         usb_nak,
  input  logic                         cpu_rd,
  input  logic                         cpu_done,
  input  logic                         cpu_clear,
  output logic [DW-1:0]                cpu_rdata,
  output logic                         cpu_rvalid,
  output logic [$clog2(MAX_PKT+1)-1:0] cpu_size,
  output logic                         rx_ready,
  output logic                         err_over,
  output logic                         err_empty
);
  import rxpp_pkg::*;

  localparam int AW     = $clog2(MAX_PKT);
  localparam int CW     = $clog2(MAX_PKT + 1);
  localparam int NHALF  = 2;

  half_st_t      half_st  [NHALF];
  logic [CW-1:0] half_cnt [NHALF];
  logic [DW-1:0] ram_q    [NHALF];

  logic          wr_sel, filling, claim, commit, discard;
  logic [CW-1:0] commit_cnt;
  logic          w_we;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;
  logic          rd_sel, release_half, r_re;
  logic [AW-1:0] r_addr;
  logic          wsel_free, sel_full;
  logic [CW-1:0] sel_cnt;

  logic          nak_q, ready_q;
  logic [CW-1:0] size_q;

  assign wsel_free = (half_st[wr_sel] == HS_FREE);
  assign sel_full  = (half_st[rd_sel] == HS_FULL);
  assign sel_cnt   = half_cnt[rd_sel];

  rxpp_fill #(.DW(DW), .MAX_PKT(MAX_PKT), .AW(AW), .CW(CW)) u_fill (
    .clk(clk), .rst(rst), .usb_wr(usb_wr), .usb_data(usb_data),
    .eop_good(usb_eop_good), .eop_bad(usb_eop_bad), .wsel_free(wsel_free),
    .wr_sel(wr_sel), .filling(filling), .claim(claim), .commit(commit),
    .discard(discard), .commit_cnt(commit_cnt),
    .ram_we(w_we), .ram_waddr(w_addr), .ram_wdata(w_data)
  );

  rxpp_reader #(.DW(DW), .MAX_PKT(MAX_PKT), .FILL_VAL(FILL_VAL), .AW(AW), .CW(CW)) u_reader (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_done(cpu_done),
    .cpu_clear(cpu_clear), .wr_sel(wr_sel), .sel_full(sel_full),
    .sel_cnt(sel_cnt), .ram_q0(ram_q[0]), .ram_q1(ram_q[1]),
    .rd_sel(rd_sel), .release_half(release_half), .ram_re(r_re),
    .ram_raddr(r_addr), .rdata(cpu_rdata), .rvalid(cpu_rvalid),
    .err_over(err_over), .err_empty(err_empty)
  );

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    logic we_g, re_g;
    assign we_g = w_we && (wr_sel == 1'(g));
    assign re_g = r_re && (rd_sel == 1'(g));

    rxpp_ram #(.DW(DW), .DEPTH(MAX_PKT), .AW(AW)) u_ram (
      .clk(clk), .we(we_g), .waddr(w_addr), .wdata(w_data),
      .re(re_g), .raddr(r_addr), .q(ram_q[g])
    );

    p_port_split_r4: assert property (@(posedge clk) disable iff (rst)
      !(we_g && re_g));
    p_commit_full_r2: assert property (@(posedge clk) disable iff (rst)
      (commit && wr_sel == 1'(g)) |=> (half_st[g] == HS_FULL));
    p_clear_spares_fill_r8: assert property (@(posedge clk) disable iff (rst)
      (cpu_clear && half_st[g] == HS_FILL && !commit && !discard) |=> (half_st[g] == HS_FILL));
    p_release_frees_r5: assert property (@(posedge clk) disable iff (rst)
      (release_half && rd_sel == 1'(g)) |=> (half_st[g] == HS_FREE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NHALF; i++) begin
        half_st[i]  <= HS_FREE;
        half_cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NHALF; i++) begin
        if (commit && wr_sel == 1'(i)) begin
          half_st[i]  <= HS_FULL;
          half_cnt[i] <= commit_cnt;
        end else if (discard && wr_sel == 1'(i)) begin
          half_st[i] <= HS_FREE;
        end else if (release_half && rd_sel == 1'(i)) begin
          half_st[i] <= HS_FREE;
        end else if (cpu_clear && half_st[i] == HS_FULL) begin
          half_st[i] <= HS_FREE;
        end else if (claim && wr_sel == 1'(i)) begin
          half_st[i] <= HS_FILL;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nak_q   <= 1'b0;
      ready_q <= 1'b0;
      size_q  <= '0;
    end else begin
      nak_q   <= !wsel_free && !filling;
      ready_q <= sel_full;
      size_q  <= sel_full ? sel_cnt : '0;
    end
  end

  assign usb_nak  = nak_q;
  assign rx_ready = ready_q;
  assign cpu_size = size_q;

  p_single_fill_r4: assert property (@(posedge clk) disable iff (rst)
    $countones({half_st[0] == HS_FILL, half_st[1] == HS_FILL}) <= 1);
  p_size_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !rx_ready |-> (cpu_size == '0));
endmodule

// File: tb/rx_pingpong_buf_tb.sv
module rx_pingpong_buf_tb;
  localparam int DW      = 8;
  localparam int MAX_PKT = 64;
  localparam int CW      = $clog2(MAX_PKT + 1);
  localparam int FILLB   = 255;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          usb_wr = 1'b0, usb_eop_good = 1'b0, usb_eop_bad = 1'b0;
  logic [DW-1:0] usb_data = '0;
  logic          cpu_rd = 1'b0, cpu_done = 1'b0, cpu_clear = 1'b0;
  logic          usb_nak, cpu_rvalid, rx_ready, err_over, err_empty;
  logic [DW-1:0] cpu_rdata;
  logic [CW-1:0] cpu_size;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  int q_tag [2];
  int q_len [2];
  int q_n = 0;
  int q_head = 0;
  int rp = 0;
  bit m_over = 0;
  bit m_empty = 0;

  always #4 clk = ~clk;

  rx_pingpong_buf #(.DW(DW), .MAX_PKT(MAX_PKT)) u_dut (
    .clk(clk), .rst(rst), .usb_wr(usb_wr), .usb_data(usb_data),
    .usb_eop_good(usb_eop_good), .usb_eop_bad(usb_eop_bad), .usb_nak(usb_nak),
    .cpu_rd(cpu_rd), .cpu_done(cpu_done), .cpu_clear(cpu_clear),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .cpu_size(cpu_size),
    .rx_ready(rx_ready), .err_over(err_over), .err_empty(err_empty)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int pkt_byte(int tag, int idx);
    return (tag * 37 + idx * 11 + 5) & 255;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_status(string req);
    check({req, " size"},  int'(cpu_size), (q_n > 0) ? q_len[q_head] : 0);
    check({req, " ready"}, int'(rx_ready), (q_n > 0) ? 1 : 0);
    check({req, " nak"},   int'(usb_nak),  (q_n == 2) ? 1 : 0);
    check({req, " err_over"},  int'(err_over),  int'(m_over));
    check({req, " err_empty"}, int'(err_empty), int'(m_empty));
  endtask

  task automatic put_byte(int b);
    usb_wr = 1'b1;
    usb_data = DW'(b);
    @(negedge clk);
    usb_wr = 1'b0;
  endtask

  task automatic pulse_eop(bit good);
    usb_eop_good = good;
    usb_eop_bad = !good;
    @(negedge clk);
    usb_eop_good = 1'b0;
    usb_eop_bad = 1'b0;
  endtask

  task automatic push_model(int len, int tag);
    q_tag[(q_head + q_n) % 2] = tag;
    q_len[(q_head + q_n) % 2] = len;
    q_n++;
  endtask

  task automatic send_pkt(int len, bit good, int tag, string req);
    bit accept;
    check({req, " R4 nak before packet"}, int'(usb_nak), (q_n == 2) ? 1 : 0);
    accept = (q_n < 2) && good && (len <= MAX_PKT);
    for (int i = 0; i < len; i++) put_byte(pkt_byte(tag, i));
    pulse_eop(good);
    @(negedge clk);
    if (accept) push_model(len, tag);
    check_status(req);
  endtask

  task automatic read_byte(string req);
    int exp;
    if (q_n == 0) begin
      exp = FILLB;
      m_empty = 1;
    end else if (rp >= q_len[q_head]) begin
      exp = FILLB;
      m_over = 1;
    end else begin
      exp = pkt_byte(q_tag[q_head], rp);
      rp++;
    end
    cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    check({req, " R10 rvalid"}, int'(cpu_rvalid), 1);
    check({req, " rdata"}, int'(cpu_rdata), exp);
    check({req, " R6 err_over"}, int'(err_over), int'(m_over));
    check({req, " R7 err_empty"}, int'(err_empty), int'(m_empty));
  endtask

  task automatic finish_rd(string req);
    cpu_done = 1'b1;
    @(negedge clk);
    cpu_done = 1'b0;
    @(negedge clk);
    if (q_n > 0) begin
      q_head = (q_head + 1) % 2;
      q_n--;
      rp = 0;
    end
    check_status(req);
  endtask

  task automatic do_clear(string req);
    cpu_clear = 1'b1;
    @(negedge clk);
    cpu_clear = 1'b0;
    @(negedge clk);
    q_n = 0;
    rp = 0;
    m_over = 0;
    m_empty = 0;
    check_status(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_status("R1 reset");

    // R7 empty read, R9 idle done
    read_byte("R7 empty read");
    finish_rd("R9 done with no packet");
    do_clear("R8 clear resets flags");

    // R2 simple packet, R10 status latency
    for (int i = 0; i < 5; i++) put_byte(pkt_byte(1, i));
    pulse_eop(1'b1);
    check("R10 ready not yet", int'(rx_ready), 0);
    @(negedge clk);
    push_model(5, 1);
    check("R10 ready after second edge", int'(rx_ready), 1);
    check_status("R2 packet of 5");
    for (int i = 0; i < 5; i++) read_byte("R2 read in order");
    read_byte("R6 over-read");
    read_byte("R6 over-read again");
    finish_rd("R5 done switches to empty half");
    do_clear("R8 clear after over-read");

    // R3 discard cases and boundary
    send_pkt(7, 1'b0, 2, "R3 bad packet");
    send_pkt(MAX_PKT + 1, 1'b1, 3, "R3 oversize packet");
    send_pkt(MAX_PKT, 1'b1, 4, "R3 max-size packet kept");
    read_byte("R3 first byte of max packet");
    finish_rd("R5 done after max packet");

    // R4 two held, third refused, order kept
    send_pkt(3, 1'b1, 5, "R4 first");
    send_pkt(9, 1'b1, 6, "R4 second");
    send_pkt(4, 1'b1, 7, "R4 third refused");
    read_byte("R4 oldest first");
    finish_rd("R5 size reloaded from second");
    read_byte("R4 second packet byte");
    send_pkt(2, 1'b1, 8, "R4 accepted after free");
    finish_rd("R5 switch to third");
    finish_rd("R5 back to empty");

    // R11 zero-length
    send_pkt(0, 1'b1, 9, "R11 zero-length");
    read_byte("R11 read of zero-length is over-read");
    finish_rd("R11 done");

    // R8 clear during fill
    send_pkt(6, 1'b1, 10, "R8 held packet");
    for (int i = 0; i < 3; i++) put_byte(pkt_byte(11, i));
    cpu_clear = 1'b1;
    @(negedge clk);
    cpu_clear = 1'b0;
    q_n = 0; rp = 0; m_over = 0; m_empty = 0;
    for (int i = 3; i < 8; i++) put_byte(pkt_byte(11, i));
    pulse_eop(1'b1);
    @(negedge clk);
    push_model(8, 11);
    check_status("R8 in-flight packet survives clear");
    read_byte("R8 in-flight data");
    finish_rd("R8 done");

    // constrained random
    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 3) begin
        send_pkt($urandom_range(0, MAX_PKT + 4), ($urandom_range(0, 4) != 0), n + 100, "R2 random packet");
      end else if (op <= 6) begin
        int k;
        k = $urandom_range(0, 6);
        for (int j = 0; j < k; j++) read_byte("R6 random read");
      end else if (op <= 8) begin
        finish_rd("R5 random done");
      end else begin
        do_clear("R8 random clear");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule